// File: doc/BRIEF.md
# Instruction Exception Classifier and Vectorer

This block sits beside the completion stage of a processor pipeline. For every instruction that completes it looks at that instruction's status flags and the current machine-state bits, and decides whether a synchronous exception must be taken. The status flags are: illegal opcode, privileged operation, move to or from a special register with a protected number, trap condition met, system call, branch, return from interrupt, floating-point operation, and the floating-point enabled-exception summary. The machine-state bits are: user mode, floating-point available, two floating-point exception mode bits, single-step and branch-trace.

When an exception is raised, the block produces a one-cycle pulse one clock after the completing instruction. With the pulse it gives a 20-bit vector offset and a 4-bit cause field for the saved-status register. All program-class conditions share a single vector. The cause field tells them apart. Trace is taken only for an instruction that raises nothing else. Fetch redirection and register update are left to the surrounding pipeline.

Top module: `insn_exc_vectorer`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, exc_valid is 0, exc_vector is 0 and exc_cause is 0.
- R2: An instruction presented with cmp_valid=1 at clock edge N that raises an exception gives exc_valid=1 in the cycle after edge N, for exactly that one cycle. An instruction on each of two consecutive edges gives two pulses on consecutive cycles. With cmp_valid=0, no flag raises a pulse. Whenever exc_valid=0, exc_vector and exc_cause are 0.
- R3: is_illegal gives vector 0x00700 and exc_cause=4'b0001 (bit 0 = illegal only). It overrides every other condition.
- R4: With st_user=1, is_priv gives vector 0x00700 and exc_cause=4'b0010 (bit 1 = privileged). So does is_sreg_move with sreg_msb=1. With st_user=0, neither raises anything. An is_sreg_move with sreg_msb=0 raises nothing.
- R5: is_fp with st_fp_ok=0 gives vector 0x00800 and exc_cause=0. It ranks below R3 and R4 and above R6, R7 and R8.
- R6: fp_exc_hit gives vector 0x00700 with cause bit 3 set only when st_fe_mode0 or st_fe_mode1 is 1. With both at 0 it has no effect.
- R7: trap_met gives vector 0x00700 with cause bit 2 set. If R6 applies to the same instruction, both bit 2 and bit 3 are set (4'b1100).
- R8: is_syscall gives vector 0x00C00 and exc_cause=0. It ranks below all program-class conditions.
- R9: An instruction that raises nothing else gives vector 0x00D00 and exc_cause=0 in either of two cases: st_step=1 and is_irq_return=0, or st_brtrace=1 and is_branch=1. A return from interrupt under single-step alone raises nothing.
- R10: Trace is suppressed when the same instruction raises any other exception. The other exception is reported instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | An instruction completes this cycle |
| is_illegal | input | 1 | Opcode is illegal or unimplemented |
| is_priv | input | 1 | Instruction is privileged |
| is_sreg_move | input | 1 | Instruction moves to or from a special register |
| sreg_msb | input | 1 | Top bit of that special-register number |
| trap_met | input | 1 | Trap condition evaluated true |
| is_syscall | input | 1 | System call instruction |
| is_branch | input | 1 | Branch instruction |
| is_irq_return | input | 1 | Return-from-interrupt instruction |
| is_fp | input | 1 | Floating-point instruction, including loads, stores and moves |
| fp_exc_hit | input | 1 | Floating-point enabled-exception summary set |
| st_user | input | 1 | Machine state: user mode |
| st_fp_ok | input | 1 | Machine state: floating point available |
| st_fe_mode0 | input | 1 | Machine state: FP exception mode bit 0 |
| st_fe_mode1 | input | 1 | Machine state: FP exception mode bit 1 |
| st_step | input | 1 | Machine state: single-step trace |
| st_brtrace | input | 1 | Machine state: branch trace |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_vector | output | 20 | Vector offset |
| exc_cause | output | 4 | Cause bits: 0 illegal, 1 privileged, 2 trap, 3 FP enabled |

## Verification
Trace can fall in the same cycle as any other exception. The sharpest case is single-step enabled while a system call, a trap or a privileged instruction completes. The bench sets the trace state bits together with each of these conditions. It then judges that the other exception's vector and cause appear and that the trace vector 0x00D00 does not. The floating-point enabled and trap causes can also coincide. The bench raises both on one instruction and expects both cause bits under the single program vector.

// File: rtl/insn_exc_pkg.sv
package insn_exc_pkg;
    localparam int CAUSE_W    = 4;
    localparam int CB_ILLEGAL = 0;
    localparam int CB_PRIV    = 1;
    localparam int CB_TRAP    = 2;
    localparam int CB_FPEN    = 3;

    typedef enum logic [2:0] {
        EK_NONE,
        EK_PROG,
        EK_FPUNAV,
        EK_SYSCALL,
        EK_TRACE
    } exc_kind_e;

    typedef struct packed {
        logic               valid;
        exc_kind_e          kind;
        logic [CAUSE_W-1:0] cause;
    } exc_pick_t;
endpackage

// File: rtl/insn_exc_prog.sv
module insn_exc_prog
    import insn_exc_pkg::*;
(
    input  logic               is_illegal,
    input  logic               is_priv,
    input  logic               is_sreg_move,
    input  logic               sreg_msb,
    input  logic               trap_met,
    input  logic               fp_exc_hit,
    input  logic               st_user,
    input  logic               st_fe_mode0,
    input  logic               st_fe_mode1,
    output logic [CAUSE_W-1:0] prog_hits
);
    logic priv_op;
    logic fe_armed;

    always_comb begin
        priv_op  = is_priv | (is_sreg_move & sreg_msb);
        fe_armed = st_fe_mode0 | st_fe_mode1;

        prog_hits             = '0;
        prog_hits[CB_ILLEGAL] = is_illegal;
        prog_hits[CB_PRIV]    = st_user & priv_op;
        prog_hits[CB_TRAP]    = trap_met;
        prog_hits[CB_FPEN]    = fp_exc_hit & fe_armed;
    end
endmodule

// File: rtl/insn_exc_trace.sv
module insn_exc_trace (
    input  logic st_step,
    input  logic st_brtrace,
    input  logic is_branch,
    input  logic is_irq_return,
    output logic trace_hit
);
    logic step_hit;
    logic branch_hit;

    always_comb begin
        step_hit   = st_step & ~is_irq_return;
        branch_hit = st_brtrace & is_branch;
        trace_hit  = step_hit | branch_hit;
    end
endmodule

// File: rtl/insn_exc_arb.sv
module insn_exc_arb
    import insn_exc_pkg::*;
(
    input  logic               cmp_valid,
    input  logic [CAUSE_W-1:0] prog_hits,
    input  logic               fp_unav,
    input  logic               syscall,
    input  logic               trace_hit,
    output exc_pick_t          pick
);
    logic [CAUSE_W-1:0] late_mask;

    always_comb begin
        late_mask          = '0;
        late_mask[CB_TRAP] = 1'b1;
        late_mask[CB_FPEN] = 1'b1;

        pick       = '0;
        pick.kind  = EK_NONE;
        if (cmp_valid) begin
            pick.valid = 1'b1;
            if (prog_hits[CB_ILLEGAL]) begin
                pick.kind              = EK_PROG;
                pick.cause[CB_ILLEGAL] = 1'b1;
            end else if (prog_hits[CB_PRIV]) begin
                pick.kind           = EK_PROG;
                pick.cause[CB_PRIV] = 1'b1;
            end else if (fp_unav) begin
                pick.kind = EK_FPUNAV;
            end else if ((prog_hits & late_mask) != '0) begin
                pick.kind  = EK_PROG;
                pick.cause = prog_hits & late_mask;
            end else if (syscall) begin
                pick.kind = EK_SYSCALL;
            end else if (trace_hit) begin
                pick.kind = EK_TRACE;
            end else begin
                pick.valid = 1'b0;
            end
        end
    end
endmodule

// File: rtl/insn_exc_vectorer.sv
module insn_exc_vectorer
    import insn_exc_pkg::*;
#(
    parameter int               VEC_W      = 20,
    parameter logic [VEC_W-1:0] VEC_PROG   = 'h00700,
    parameter logic [VEC_W-1:0] VEC_FPUNAV = 'h00800,
    parameter logic [VEC_W-1:0] VEC_SYSC   = 'h00C00,
    parameter logic [VEC_W-1:0] VEC_TRACE  = 'h00D00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmp_valid,
    input  logic               is_illegal,
    input  logic               is_priv,
    input  logic               is_sreg_move,
    input  logic               sreg_msb,
    input  logic               trap_met,
    input  logic               is_syscall,
    input  logic               is_branch,
    input  logic               is_irq_return,
    input  logic               is_fp,
    input  logic               fp_exc_hit,
    input  logic               st_user,
    input  logic               st_fp_ok,
    input  logic               st_fe_mode0,
    input  logic               st_fe_mode1,
    input  logic               st_step,
    input  logic               st_brtrace,
    output logic               exc_valid,
    output logic [VEC_W-1:0]   exc_vector,
    output logic [CAUSE_W-1:0] exc_cause
);
    typedef struct packed {
        logic               valid;
        logic [VEC_W-1:0]   vector;
        logic [CAUSE_W-1:0] cause;
    } out_state_t;

    logic [CAUSE_W-1:0] prog_hits;
    logic               trace_hit;
    logic               fp_unav;
    exc_pick_t          pick;
    out_state_t         st_d;
    out_state_t         st_q;

    assign fp_unav = is_fp & ~st_fp_ok;

    insn_exc_prog u_prog (
        .is_illegal   (is_illegal),
        .is_priv      (is_priv),
        .is_sreg_move (is_sreg_move),
        .sreg_msb     (sreg_msb),
        .trap_met     (trap_met),
        .fp_exc_hit   (fp_exc_hit),
        .st_user      (st_user),
        .st_fe_mode0  (st_fe_mode0),
        .st_fe_mode1  (st_fe_mode1),
        .prog_hits    (prog_hits)
    );

    insn_exc_trace u_trace (
        .st_step       (st_step),
        .st_brtrace    (st_brtrace),
        .is_branch     (is_branch),
        .is_irq_return (is_irq_return),
        .trace_hit     (trace_hit)
    );

    insn_exc_arb u_arb (
        .cmp_valid (cmp_valid),
        .prog_hits (prog_hits),
        .fp_unav   (fp_unav),
        .syscall   (is_syscall),
        .trace_hit (trace_hit),
        .pick      (pick)
    );

    always_comb begin
        st_d       = '0;
        st_d.valid = pick.valid;
        st_d.cause = pick.cause;
        unique case (pick.kind)
            EK_PROG:    st_d.vector = VEC_PROG;
            EK_FPUNAV:  st_d.vector = VEC_FPUNAV;
            EK_SYSCALL: st_d.vector = VEC_SYSC;
            EK_TRACE:   st_d.vector = VEC_TRACE;
            default:    st_d.vector = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign exc_valid  = st_q.valid;
    assign exc_vector = st_q.vector;
    assign exc_cause  = st_q.cause;
endmodule

// File: rtl/insn_exc_checker.sv
module insn_exc_checker
    import insn_exc_pkg::*;
#(
    parameter int               VEC_W      = 20,
    parameter logic [VEC_W-1:0] VEC_PROG   = 'h00700,
    parameter logic [VEC_W-1:0] VEC_FPUNAV = 'h00800,
    parameter logic [VEC_W-1:0] VEC_SYSC   = 'h00C00,
    parameter logic [VEC_W-1:0] VEC_TRACE  = 'h00D00
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmp_valid,
    input logic               is_illegal,
    input logic               is_priv,
    input logic               st_user,
    input logic               st_fe_mode0,
    input logic               st_fe_mode1,
    input logic               exc_valid,
    input logic [VEC_W-1:0]   exc_vector,
    input logic [CAUSE_W-1:0] exc_cause
);
    localparam logic [CAUSE_W-1:0] C_ILL  = CAUSE_W'(1) << CB_ILLEGAL;
    localparam logic [CAUSE_W-1:0] C_PRIV = CAUSE_W'(1) << CB_PRIV;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |-> (exc_vector == '0 && exc_cause == '0)); // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> !exc_valid); // R2

    AST_KNOWN_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_vector == VEC_PROG || exc_vector == VEC_FPUNAV ||
                       exc_vector == VEC_SYSC || exc_vector == VEC_TRACE)); // R2

    AST_ILLEGAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && is_illegal) |=>
        (exc_valid && exc_vector == VEC_PROG && exc_cause == C_ILL)); // R3

    AST_PRIV_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !is_illegal && st_user && is_priv) |=>
        (exc_valid && exc_vector == VEC_PROG && exc_cause == C_PRIV)); // R4

    AST_CAUSE_PROG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_vector != VEC_PROG) |-> exc_cause == '0); // R5

    AST_FE_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !st_fe_mode0 && !st_fe_mode1) |=> !exc_cause[CB_FPEN]); // R6
endmodule

bind insn_exc_vectorer insn_exc_checker #(
    .VEC_W      (VEC_W),
    .VEC_PROG   (VEC_PROG),
    .VEC_FPUNAV (VEC_FPUNAV),
    .VEC_SYSC   (VEC_SYSC),
    .VEC_TRACE  (VEC_TRACE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_valid   (cmp_valid),
    .is_illegal  (is_illegal),
    .is_priv     (is_priv),
    .st_user     (st_user),
    .st_fe_mode0 (st_fe_mode0),
    .st_fe_mode1 (st_fe_mode1),
    .exc_valid   (exc_valid),
    .exc_vector  (exc_vector),
    .exc_cause   (exc_cause)
);

// File: tb/insn_exc_vectorer_tb.sv
module insn_exc_vectorer_tb;
    localparam logic [19:0] V_PROG  = 20'h00700;
    localparam logic [19:0] V_FPU   = 20'h00800;
    localparam logic [19:0] V_SYSC  = 20'h00C00;
    localparam logic [19:0] V_TRACE = 20'h00D00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_valid = 0, is_illegal = 0, is_priv = 0, is_sreg_move = 0, sreg_msb = 0;
    logic trap_met = 0, is_syscall = 0, is_branch = 0, is_irq_return = 0, is_fp = 0;
    logic fp_exc_hit = 0, st_user = 0, st_fp_ok = 1, st_fe_mode0 = 0, st_fe_mode1 = 0;
    logic st_step = 0, st_brtrace = 0;
    logic        exc_valid;
    logic [19:0] exc_vector;
    logic [3:0]  exc_cause;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    insn_exc_vectorer u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .is_illegal(is_illegal),
        .is_priv(is_priv), .is_sreg_move(is_sreg_move), .sreg_msb(sreg_msb),
        .trap_met(trap_met), .is_syscall(is_syscall), .is_branch(is_branch),
        .is_irq_return(is_irq_return), .is_fp(is_fp), .fp_exc_hit(fp_exc_hit),
        .st_user(st_user), .st_fp_ok(st_fp_ok), .st_fe_mode0(st_fe_mode0),
        .st_fe_mode1(st_fe_mode1), .st_step(st_step), .st_brtrace(st_brtrace),
        .exc_valid(exc_valid), .exc_vector(exc_vector), .exc_cause(exc_cause)
    );

    task automatic check_out(input string tag, input logic ev,
                             input logic [19:0] vec, input logic [3:0] cs);
        logic [24:0] act;
        logic [24:0] exp;
        act = {exc_valid, exc_vector, exc_cause};
        exp = {ev, (ev ? vec : 20'h0), (ev ? cs : 4'h0)};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual valid=%0b vec=%05h cause=%04b expected valid=%0b vec=%05h cause=%04b",
                     tag, act[24], act[23:4], act[3:0], exp[24], exp[23:4], exp[3:0]);
        end
    endtask

    task automatic clear_flags();
        is_illegal = 0; is_priv = 0; is_sreg_move = 0; sreg_msb = 0; trap_met = 0;
        is_syscall = 0; is_branch = 0; is_irq_return = 0; is_fp = 0; fp_exc_hit = 0;
        st_user = 0; st_fp_ok = 1; st_fe_mode0 = 0; st_fe_mode1 = 0;
        st_step = 0; st_brtrace = 0;
    endtask

    // Flags are set by the caller while cmp_valid is 0; one instruction completes.
    task automatic fire(input string tag, input logic ev,
                        input logic [19:0] vec, input logic [3:0] cs);
        @(negedge clk);
        cmp_valid = 1;
        @(posedge clk);
        #2;
        check_out(tag, ev, vec, cs);
        @(negedge clk);
        cmp_valid = 0;
        clear_flags();
    endtask

    task automatic t_reset();
        #5;
        check_out("R1 during reset", 0, 0, 0);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        #2;
        check_out("R1 after release", 0, 0, 0);
    endtask

    task automatic t_timing();
        is_illegal = 1;
        @(negedge clk);
        @(posedge clk);
        #2;
        check_out("R2 no completion", 0, 0, 0);
        clear_flags();
        is_syscall = 1;
        fire("R2 pulse", 1, V_SYSC, 4'b0000);
        @(posedge clk);
        #2;
        check_out("R2 pulse ends", 0, 0, 0);
        @(negedge clk);
        cmp_valid = 1; is_syscall = 1;
        @(posedge clk);
        #2;
        check_out("R2 back-to-back first", 1, V_SYSC, 4'b0000);
        @(negedge clk);
        is_syscall = 0; is_illegal = 1;
        @(posedge clk);
        #2;
        check_out("R2 back-to-back second", 1, V_PROG, 4'b0001);
        @(negedge clk);
        cmp_valid = 0; clear_flags();
        @(posedge clk);
        #2;
        check_out("R2 idle after pair", 0, 0, 0);
    endtask

    task automatic t_illegal();
        is_illegal = 1;
        fire("R3 illegal alone", 1, V_PROG, 4'b0001);
        is_illegal = 1; is_priv = 1; st_user = 1; is_fp = 1; st_fp_ok = 0;
        trap_met = 1; is_syscall = 1; st_step = 1;
        fire("R3 illegal over all", 1, V_PROG, 4'b0001);
    endtask

    task automatic t_priv();
        is_priv = 1; st_user = 1;
        fire("R4 priv user", 1, V_PROG, 4'b0010);
        is_priv = 1; st_user = 0;
        fire("R4 priv supervisor", 0, 0, 0);
        is_sreg_move = 1; sreg_msb = 1; st_user = 1;
        fire("R4 sreg msb user", 1, V_PROG, 4'b0010);
        is_sreg_move = 1; sreg_msb = 1; st_user = 0;
        fire("R4 sreg msb supervisor", 0, 0, 0);
        is_sreg_move = 1; sreg_msb = 0; st_user = 1;
        fire("R4 sreg low user", 0, 0, 0);
    endtask

    task automatic t_fpunav();
        is_fp = 1; st_fp_ok = 0;
        fire("R5 fp unavailable", 1, V_FPU, 4'b0000);
        is_fp = 1; st_fp_ok = 1;
        fire("R5 fp available", 0, 0, 0);
        is_fp = 1; st_fp_ok = 0; trap_met = 1; fp_exc_hit = 1; st_fe_mode0 = 1; is_syscall = 1;
        fire("R5 over trap/fpen/syscall", 1, V_FPU, 4'b0000);
        is_fp = 1; st_fp_ok = 0; is_priv = 1; st_user = 1;
        fire("R5 below priv", 1, V_PROG, 4'b0010);
    endtask

    task automatic t_fpen();
        fp_exc_hit = 1; st_fe_mode0 = 1;
        fire("R6 mode0", 1, V_PROG, 4'b1000);
        fp_exc_hit = 1; st_fe_mode1 = 1;
        fire("R6 mode1", 1, V_PROG, 4'b1000);
        fp_exc_hit = 1;
        fire("R6 modes off ignored", 0, 0, 0);
    endtask

    task automatic t_trap();
        trap_met = 1;
        fire("R7 trap", 1, V_PROG, 4'b0100);
        trap_met = 1; fp_exc_hit = 1; st_fe_mode1 = 1;
        fire("R7 trap and fpen", 1, V_PROG, 4'b1100);
        trap_met = 1; fp_exc_hit = 1;
        fire("R7 trap fpen disarmed", 1, V_PROG, 4'b0100);
    endtask

    task automatic t_syscall();
        is_syscall = 1;
        fire("R8 syscall", 1, V_SYSC, 4'b0000);
        is_syscall = 1; trap_met = 1;
        fire("R8 below trap", 1, V_PROG, 4'b0100);
    endtask

    task automatic t_trace();
        st_step = 1;
        fire("R9 single step", 1, V_TRACE, 4'b0000);
        st_step = 1; is_irq_return = 1;
        fire("R9 step on irq return", 0, 0, 0);
        st_brtrace = 1; is_branch = 1;
        fire("R9 branch trace", 1, V_TRACE, 4'b0000);
        st_brtrace = 1;
        fire("R9 branch trace non-branch", 0, 0, 0);
        st_brtrace = 1; is_branch = 1; is_irq_return = 1;
        fire("R9 branch trace irq-return branch", 1, V_TRACE, 4'b0000);
    endtask

    task automatic t_trace_masked();
        st_step = 1; is_syscall = 1;
        fire("R10 step with syscall", 1, V_SYSC, 4'b0000);
        st_step = 1; st_brtrace = 1; is_branch = 1; trap_met = 1;
        fire("R10 trace with trap", 1, V_PROG, 4'b0100);
        st_step = 1; is_priv = 1; st_user = 1;
        fire("R10 step with priv", 1, V_PROG, 4'b0010);
        st_step = 1; is_fp = 1; st_fp_ok = 0;
        fire("R10 step with fp unavailable", 1, V_FPU, 4'b0000);
    endtask

    initial begin
        t_reset();
        t_timing();
        t_illegal();
        t_priv();
        t_fpunav();
        t_fpen();
        t_trap();
        t_syscall();
        t_trace();
        t_trace_masked();
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual run still active expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule